// File: doc/BRIEF.md
# Reference-Counted Rename Register Manager

This block keeps track of a small pool of rename registers for an out-of-order core whose reservation station reads source operands at dispatch time rather than at issue time. Each issued instruction receives a free rename register for its destination. Its two source operands are translated through a mapping table into either a rename-register tag or a plain architectural index. The block also holds the rename-register values, the architectural register file, and one reference counter per rename register.

The reservation station keeps renamed source tags until dispatch and is never told when a result arrives. A completed rename register may therefore still have readers. The block frees a register only after its instruction has completed and its counter of outstanding source fetches has drained to zero, in whichever order those two events occur. Completion copies the value into the architectural register named by the instruction's destination and removes the mapping entry if it still refers to that rename register. Waiting source tags are never redirected to the architectural register.

Four ports drive the block. The issue port allocates and renames. The dispatch fetch port reads two operands per cycle. The result port writes execution results. The completion port retires results.

Top module: `rr_rename_mgr`

## Requirements
- R1: After reset all rename registers are free, every counter is zero, the mapping table is empty (every lookup returns the architectural index with the rename flag low), and all rename and architectural values read as zero.
- R2: `iss_ready_o` is high when at least one rename register is free. `iss_tag_o` shows the lowest-numbered free register, or 0 when none is free. An issue with `iss_ready_o` low has no effect on any state.
- R3: For each source p, `iss_src_ren_o[p]` is 1 and `iss_src_idx_o[p]` holds the zero-extended rename tag when a mapping entry exists. Otherwise the flag is 0 and the index is the architectural index. Lookups are combinational and use the table as it stood before the same cycle's issue. An accepted issue replaces any older entry for its destination.
- R4: Every source of an accepted issue that is renamed to a register increments that register's counter by one, so two sources naming the same register add two.
- R5: Every valid fetch lane with `fch_ren_i[p]`=1 decrements the counter of rename register `fch_idx_i[p][RW-1:0]` by one. A fetch with `fch_ren_i[p]`=0 reads the architectural file and leaves all counters unchanged.
- R6: When increments from issue and decrements from dispatch hit the same register in one cycle, the counter takes the net change.
- R7: A result write to an allocated register stores the data and marks the result available. `fch_data_o[p]` returns the addressed rename or architectural value combinationally in the same cycle.
- R8: A completion for a register whose result is available copies its value into the architectural register recorded as its destination, visible from the next cycle.
- R9: Completion removes the destination's mapping entry only if that entry still holds the completing tag. A newer mapping is left intact.
- R10: A rename register returns to the pool at the clock edge where it is completed and its counter is zero, reached in either order.
- R11: After completion, fetches through the register's tag still return the rename register's value until it is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | A rename register is free; issue accepted |
| iss_dst_i | input | AW | Destination architectural register |
| iss_src_i | input | 2 x AW | Source architectural registers |
| iss_tag_o | output | RW | Rename register granted to this issue |
| iss_src_ren_o | output | 2 | Per source: 1 = renamed |
| iss_src_idx_o | output | 2 x AW | Per source: rename tag or architectural index |
| fch_valid_i | input | 2 | Dispatch fetch lane valid |
| fch_ren_i | input | 2 | Lane reads rename file (1) or architectural file (0) |
| fch_idx_i | input | 2 x AW | Lane read index |
| fch_data_o | output | 2 x DATA_W | Lane read data |
| wr_valid_i | input | 1 | Result write |
| wr_tag_i | input | RW | Rename register receiving the result |
| wr_data_i | input | DATA_W | Result value |
| cmp_valid_i | input | 1 | Completion |
| cmp_tag_i | input | RW | Rename register being completed |

## Verification
Issue and dispatch can both move the same reference counter in one cycle. Two sources of an issue that map to one register are accepted together with a dispatch fetch from that register. The test then completes the register and watches the pool. The register may only rejoin the pool after exactly one further fetch, and this is judged at `iss_ready_o` and `iss_tag_o` with the pool otherwise full. A second overlap, a completion that comes after the counter has already drained, checks that the register is freed at the completion edge itself.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    RS_FREE  = 2'd0,
    RS_ALLOC = 2'd1,
    RS_AVAIL = 2'd2,
    RS_DONE  = 2'd3
  } ren_state_e;

endpackage

// File: rtl/rr_free_pick.sv
module rr_free_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] free_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  // lowest index wins; idx 0 when nothing is free
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

endmodule

// File: rtl/rr_ref_cnt.sv
module rr_ref_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       inc_i,
  input  logic [1:0]       dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  assign cnt_nxt_o = cnt_o + CNT_W'(inc_i) - CNT_W'(dec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_nxt_o;
  end

endmodule

// File: rtl/rr_map_table.sv
module rr_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_REN  = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int RW = $clog2(NUM_REN)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0][AW-1:0]           src_i,
  output logic [1:0]                   src_vld_o,
  output logic [1:0][RW-1:0]           src_tag_o,
  input  logic                         set_i,
  input  logic [AW-1:0]                set_arch_i,
  input  logic [RW-1:0]                set_tag_i,
  input  logic                         clr_i,
  input  logic [AW-1:0]                clr_arch_i,
  input  logic [RW-1:0]                clr_tag_i,
  output logic [NUM_ARCH-1:0]          map_vld_o,
  output logic [NUM_ARCH-1:0][RW-1:0]  map_tag_o
);

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      src_vld_o[p] = map_vld_o[src_i[p]];
      src_tag_o[p] = map_tag_o[src_i[p]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_vld_o <= '0;
      map_tag_o <= '0;
    end else begin
      // drop only an entry that still names the retiring tag
      if (clr_i && map_vld_o[clr_arch_i] && map_tag_o[clr_arch_i] == clr_tag_i)
        map_vld_o[clr_arch_i] <= 1'b0;
      // a new allocation overrides a same-cycle clear
      if (set_i) begin
        map_vld_o[set_arch_i] <= 1'b1;
        map_tag_o[set_arch_i] <= set_tag_i;
      end
    end
  end

endmodule

// File: rtl/rr_rename_mgr.sv
module rr_rename_mgr
  import rr_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_REN  = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int RW = $clog2(NUM_REN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   iss_valid_i,
  output logic                   iss_ready_o,
  input  logic [AW-1:0]          iss_dst_i,
  input  logic [1:0][AW-1:0]     iss_src_i,
  output logic [RW-1:0]          iss_tag_o,
  output logic [1:0]             iss_src_ren_o,
  output logic [1:0][AW-1:0]     iss_src_idx_o,
  input  logic [1:0]             fch_valid_i,
  input  logic [1:0]             fch_ren_i,
  input  logic [1:0][AW-1:0]     fch_idx_i,
  output logic [1:0][DATA_W-1:0] fch_data_o,
  input  logic                   wr_valid_i,
  input  logic [RW-1:0]          wr_tag_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   cmp_valid_i,
  input  logic [RW-1:0]          cmp_tag_i
);

  ren_state_e [NUM_REN-1:0]             state_q, state_d;
  logic [NUM_REN-1:0][AW-1:0]           dst_q;
  logic [NUM_REN-1:0][DATA_W-1:0]       ren_data_q;
  logic [NUM_ARCH-1:0][DATA_W-1:0]      arf_q;
  logic [NUM_REN-1:0][CNT_W-1:0]        cnt_q, cnt_d;
  logic [NUM_REN-1:0][1:0]              inc, dec;
  logic [NUM_ARCH-1:0]                  map_vld;
  logic [NUM_ARCH-1:0][RW-1:0]          map_tag;
  logic [NUM_REN-1:0]                   free_vec;
  logic                                 any_free;
  logic [RW-1:0]                        pick;
  logic                                 iss_fire, cmp_fire;
  logic [AW-1:0]                        cmp_dst;
  logic [1:0]                           lk_vld;
  logic [1:0][RW-1:0]                   lk_tag;

  always_comb begin
    for (int i = 0; i < NUM_REN; i++) free_vec[i] = (state_q[i] == RS_FREE);
  end

  rr_free_pick #(.N(NUM_REN)) u_pick (
    .free_i (free_vec),
    .any_o  (any_free),
    .idx_o  (pick)
  );

  assign iss_ready_o = any_free;
  assign iss_tag_o   = pick;
  assign iss_fire    = iss_valid_i && any_free;
  assign cmp_fire    = cmp_valid_i && (state_q[cmp_tag_i] == RS_AVAIL);
  assign cmp_dst     = dst_q[cmp_tag_i];

  rr_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_REN(NUM_REN)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (iss_src_i),
    .src_vld_o  (lk_vld),
    .src_tag_o  (lk_tag),
    .set_i      (iss_fire),
    .set_arch_i (iss_dst_i),
    .set_tag_i  (pick),
    .clr_i      (cmp_fire),
    .clr_arch_i (cmp_dst),
    .clr_tag_i  (cmp_tag_i),
    .map_vld_o  (map_vld),
    .map_tag_o  (map_tag)
  );

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      iss_src_ren_o[p] = lk_vld[p];
      iss_src_idx_o[p] = lk_vld[p] ? AW'(lk_tag[p]) : iss_src_i[p];
      fch_data_o[p]    = fch_ren_i[p] ? ren_data_q[fch_idx_i[p][RW-1:0]]
                                      : arf_q[fch_idx_i[p]];
    end
  end

  // per-register reference deltas, up to two each way per cycle
  always_comb begin
    for (int i = 0; i < NUM_REN; i++) begin
      inc[i] = 2'd0;
      dec[i] = 2'd0;
      for (int p = 0; p < 2; p++) begin
        if (iss_fire && lk_vld[p] && lk_tag[p] == RW'(i))
          inc[i] = inc[i] + 2'd1;
        if (fch_valid_i[p] && fch_ren_i[p] && fch_idx_i[p][RW-1:0] == RW'(i))
          dec[i] = dec[i] + 2'd1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REN; g++) begin : g_cnt
    rr_ref_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc[g]),
      .dec_i     (dec[g]),
      .cnt_o     (cnt_q[g]),
      .cnt_nxt_o (cnt_d[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_REN; i++) begin
      state_d[i] = state_q[i];
      case (state_q[i])
        RS_FREE:  if (iss_fire && pick == RW'(i))          state_d[i] = RS_ALLOC;
        RS_ALLOC: if (wr_valid_i && wr_tag_i == RW'(i))    state_d[i] = RS_AVAIL;
        RS_AVAIL: if (cmp_fire && cmp_tag_i == RW'(i))     state_d[i] = RS_DONE;
        default:  ;
      endcase
      // reclaim once retired and no reader is left
      if (state_d[i] == RS_DONE && cnt_d[i] == '0) state_d[i] = RS_FREE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REN; i++) state_q[i] <= RS_FREE;
      dst_q      <= '0;
      ren_data_q <= '0;
      arf_q      <= '0;
    end else begin
      state_q <= state_d;
      if (iss_fire) dst_q[pick] <= iss_dst_i;
      if (wr_valid_i && state_q[wr_tag_i] == RS_ALLOC)
        ren_data_q[wr_tag_i] <= wr_data_i;
      if (cmp_fire) arf_q[cmp_dst] <= ren_data_q[cmp_tag_i];
    end
  end

endmodule

// File: rtl/rr_rename_mgr_chk.sv
module rr_rename_mgr_chk
  import rr_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_REN  = 4,
  parameter int CNT_W    = 4,
  localparam int RW = $clog2(NUM_REN)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        iss_valid_i,
  input logic                        iss_ready_o,
  input logic [RW-1:0]               iss_tag_o,
  input ren_state_e [NUM_REN-1:0]    state_q,
  input logic [NUM_REN-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_ARCH-1:0]         map_vld,
  input logic [NUM_ARCH-1:0][RW-1:0] map_tag
);

  // R2: the granted tag is a free register
  a_r2_tag_is_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_ready_o |-> state_q[iss_tag_o] == RS_FREE);

  // R2: an accepted issue leaves its register allocated
  a_r2_alloc_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_ready_o) |=> state_q[$past(iss_tag_o)] == RS_ALLOC);

  for (genvar i = 0; i < NUM_REN; i++) begin : g_ren
    // R10: reclaim only with a drained counter
    a_r10_free_cnt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[i] == RS_FREE && $past(state_q[i]) != RS_FREE) |-> cnt_q[i] == '0);
    // R10: reclaim only from a retiring or retired register
    a_r10_free_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[i] == RS_FREE && $past(state_q[i]) != RS_FREE)
        |-> ($past(state_q[i]) == RS_DONE || $past(state_q[i]) == RS_AVAIL));
  end

  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_arch
    // R9: a live mapping never names a free register
    a_r9_map_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
      map_vld[a] |-> state_q[map_tag[a]] != RS_FREE);
  end

endmodule

bind rr_rename_mgr rr_rename_mgr_chk #(
  .NUM_ARCH (NUM_ARCH),
  .NUM_REN  (NUM_REN),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_ready_o (iss_ready_o),
  .iss_tag_o   (iss_tag_o),
  .state_q     (state_q),
  .cnt_q       (cnt_q),
  .map_vld     (map_vld),
  .map_tag     (map_tag)
);

// File: tb/tb_rr_rename_mgr.sv
`timescale 1ns/1ps
module tb_rr_rename_mgr;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             iss_valid;
  logic             iss_ready;
  logic [2:0]       iss_dst;
  logic [1:0][2:0]  iss_src;
  logic [1:0]       iss_tag;
  logic [1:0]       src_ren;
  logic [1:0][2:0]  src_idx;
  logic [1:0]       fch_valid, fch_ren;
  logic [1:0][2:0]  fch_idx;
  logic [1:0][15:0] fch_data;
  logic             wr_valid;
  logic [1:0]       wr_tag;
  logic [15:0]      wr_data;
  logic             cmp_valid;
  logic [1:0]       cmp_tag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rr_rename_mgr dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid), .iss_ready_o(iss_ready), .iss_dst_i(iss_dst),
    .iss_src_i(iss_src), .iss_tag_o(iss_tag), .iss_src_ren_o(src_ren),
    .iss_src_idx_o(src_idx),
    .fch_valid_i(fch_valid), .fch_ren_i(fch_ren), .fch_idx_i(fch_idx),
    .fch_data_o(fch_data),
    .wr_valid_i(wr_valid), .wr_tag_i(wr_tag), .wr_data_i(wr_data),
    .cmp_valid_i(cmp_valid), .cmp_tag_i(cmp_tag)
  );

  typedef struct packed {
    logic       iv;  logic [2:0] dst; logic [2:0] s0;  logic [2:0] s1;
    logic [1:0] fv;  logic [1:0] fr;  logic [2:0] fi0; logic [2:0] fi1;
    logic       wv;  logic [1:0] wt;  logic [15:0] wd;
    logic       cv;  logic [1:0] ct;
    logic       rdy; logic [1:0] tag; logic [1:0] sren;
    logic [2:0] x0;  logic [2:0] x1;  logic [15:0] d0; logic [15:0] d1;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1,1,2,3, 0,0,0,0, 0,0,0,      0,0, 1,0,2'b00,2,3,0,0,            2},  // R2 first grant, R3 unmapped
    '{1,2,1,1, 0,0,0,0, 0,0,0,      0,0, 1,1,2'b11,0,0,0,0,            4},  // R4 two refs to one tag
    '{1,1,1,4, 0,0,0,0, 1,0,'h1111, 0,0, 1,2,2'b01,0,4,0,0,            3},  // R3 old map seen, then replaced
    '{0,0,1,2, 1,1,0,0, 0,0,0,      0,0, 1,3,2'b11,2,1,'h1111,0,       7},  // R7 read result, R5 one fetch
    '{0,0,1,5, 2,0,0,1, 0,0,0,      1,0, 1,3,2'b01,2,5,0,0,            9},  // R9 newer map kept
    '{0,0,1,5, 2,0,0,1, 0,0,0,      0,0, 1,3,2'b01,2,5,0,'h1111,       8},  // R8 value copied
    '{1,3,6,7, 0,0,0,0, 0,0,0,      0,0, 1,3,2'b00,6,7,0,0,            2},  // R2 last free register
    '{1,4,4,3, 3,3,0,0, 0,0,0,      0,0, 0,0,2'b10,4,3,'h1111,'h1111,  2},  // R2 empty, R5 double fetch
    '{0,0,4,3, 0,0,0,0, 0,0,0,      0,0, 1,0,2'b10,4,3,0,0,           10},  // R10 drained, R2 issue ignored
    '{1,5,2,2, 1,1,1,0, 0,0,0,      0,0, 1,0,2'b11,1,1,0,0,            6},  // R6 +2 and -1 together
    '{0,0,0,0, 0,0,0,0, 1,1,'h2222, 0,0, 0,0,2'b00,0,0,0,0,            7},  // R7 write result
    '{0,0,2,0, 0,0,0,0, 0,0,0,      1,1, 0,0,2'b01,1,0,0,0,            9},  // R9 complete own mapping
    '{0,0,2,0, 3,1,1,2, 0,0,0,      0,0, 0,0,2'b00,2,0,'h2222,'h2222, 11},  // R11 tag still readable, R9 removed
    '{1,6,2,0, 0,0,0,0, 0,0,0,      0,0, 1,1,2'b00,2,0,0,0,           10},  // R10 freed after last fetch
    '{0,0,1,6, 0,0,0,0, 1,2,'h3333, 0,0, 0,0,2'b11,2,1,0,0,            3},  // R3 live entries
    '{0,0,1,6, 2,0,0,1, 0,0,0,      1,2, 0,0,2'b11,2,1,0,'h1111,       9},  // R8 old arch value still
    '{1,1,1,6, 2,0,0,1, 0,0,0,      0,0, 1,2,2'b10,1,1,0,'h3333,      10},  // R10 freed at completion edge
    '{0,0,1,3, 0,0,0,0, 0,0,0,      0,0, 0,0,2'b11,2,3,0,0,            3}   // R3 source before own dest
  };

  task automatic idle();
    iss_valid = 0; iss_dst = '0; iss_src = '0;
    fch_valid = '0; fch_ren = '0; fch_idx = '0;
    wr_valid = 0; wr_tag = '0; wr_data = '0;
    cmp_valid = 0; cmp_tag = '0;
  endtask

  task automatic compare(input int req, input logic [46:0] act, input logic [46:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d vector %0d: actual %h expected %h", req, n_vec, act, exp);
    end
  endtask

  function automatic logic [46:0] observed();
    return {iss_ready, iss_tag, src_ren, src_idx[1], src_idx[0], fch_data[1], fch_data[0]};
  endfunction

  // R1 reset picture: all free, nothing mapped, arch and rename reads zero
  task automatic check_reset();
    @(negedge clk);
    idle();
    iss_src = {3'd1, 3'd5};
    fch_ren = 2'b01; fch_idx = {3'd1, 3'd3};
    #3;
    compare(1, observed(), {1'b1, 2'd0, 2'b00, 3'd1, 3'd5, 16'h0, 16'h0});
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check_reset();  // R1
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      iss_valid = VECS[k].iv; iss_dst = VECS[k].dst;
      iss_src   = {VECS[k].s1, VECS[k].s0};
      fch_valid = VECS[k].fv; fch_ren = VECS[k].fr;
      fch_idx   = {VECS[k].fi1, VECS[k].fi0};
      wr_valid  = VECS[k].wv; wr_tag = VECS[k].wt; wr_data = VECS[k].wd;
      cmp_valid = VECS[k].cv; cmp_tag = VECS[k].ct;
      #3;
      compare(int'(VECS[k].req), observed(),
              {VECS[k].rdy, VECS[k].tag, VECS[k].sren, VECS[k].x1, VECS[k].x0,
               VECS[k].d1, VECS[k].d0});
    end
    // R1 reset in mid-run clears mappings, pool and architectural values
    @(negedge clk);
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    check_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule